// File: doc/BRIEF.md
# ECC Write Error Injector

This block sits on the write data path of a memory controller, beside the ECC encoder. Each write chunk carries 64 data bits and an 8-bit check byte. When a programmed trigger fires, the block inverts two fixed bits of that chunk's check byte. A SECDED decoder that later reads the chunk then reports an uncorrectable error. Chunks that are not selected pass through unchanged, in the same cycle.

Software picks one of three trigger sources through a 3-bit mode register:
- a one-shot armed by an external latency indication pulse;
- a masked compare of address bits 37..6;
- a countdown of valid write chunks that reloads each time it expires.

A flag output marks every corrupted chunk for one cycle.

Top module: `ecc_wr_injector`

## Requirements
- R1: After reset the mode is 000, the reload value, compare and mask are zero, no chunk is corrupted, and `chk_o` equals `chk_i`.
- R2: A register write (`cfg_we_i` high) stores `cfg_wdata_i` into the register chosen by `cfg_sel_i`: 0 = mode (bits 2..0), 1 = countdown reload value, 2 = address compare, 3 = address mask.
- R3: A corrupted chunk has check bits 0 and 1 inverted and all other check bits unchanged. `inj_o` is high in the same cycle. When `inj_o` is low, `chk_o` equals `chk_i`.
- R4: Mode 110 and every mode with bit 2 clear never corrupt a chunk, whatever the pulse or address inputs do.
- R5: In mode 100, a latency pulse arms a one-shot. The first valid chunk in the cycle of the pulse or after it is corrupted, and the one-shot is then spent. Further pulses while armed do not add more corruptions. A pulse outside mode 100 arms nothing.
- R6: In mode 101, every valid chunk whose `wr_addr_i & mask` equals the compare register is corrupted. Other chunks are not.
- R7: In mode 111 with reload value N > 0, the counter decrements once per valid chunk. The chunk on which it expires (the Nth) is corrupted and the counter reloads to N, so every Nth chunk is corrupted.
- R8: Writing the reload register also loads the counter at once. A reload value of 0 disables countdown injection.
- R9: The counter advances, and reloads on expiry, in modes 110 and 111 only. In mode 110 it never corrupts a chunk. In all other modes it holds its value.
- R10: A cycle with `wr_valid_i` low never corrupts, never advances the counter and never spends an armed one-shot.
- R11: Leaving mode 100 discards an armed one-shot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select (0 mode, 1 reload, 2 compare, 3 mask) |
| cfg_wdata_i | input | 32 | Register write data |
| wr_valid_i | input | 1 | Write chunk valid |
| wr_addr_i | input | ADDR_W (32) | Chunk address bits 37..6 |
| lat_pulse_i | input | 1 | Latency indication pulse |
| chk_i | input | CHK_W (8) | Incoming check byte |
| chk_o | output | CHK_W (8) | Check byte, possibly corrupted |
| inj_o | output | 1 | High for the cycle of a corrupted chunk |

## Verification
The bench builds the block with its defaults: 8 check bits, a 32-bit counter, a 32-bit address slice and the flip pair at bits 0 and 1. Because a write to the reload register also loads the counter, small reload values of 1 and 3 reach expiry, reload and back-to-back injection within a few chunks, even though the counter is 32 bits wide. A mask with its low half cleared lets two distinct addresses match and a third miss, which exercises the masked compare on both sides.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
  typedef enum logic [2:0] {
    MODE_OFF   = 3'b000,
    MODE_PULSE = 3'b100,
    MODE_ADDR  = 3'b101,
    MODE_RSVD  = 3'b110,
    MODE_COUNT = 3'b111
  } inj_mode_e;

  typedef enum logic [1:0] {
    SEL_MODE  = 2'd0,
    SEL_RLD   = 2'd1,
    SEL_CMP   = 2'd2,
    SEL_MASK  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/ecc_inj_regs.sv
module ecc_inj_regs #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [2:0]        mode_o,
  output logic [CNT_W-1:0]  rld_o,
  output logic              rld_load_o,
  output logic [ADDR_W-1:0] cmp_o,
  output logic [ADDR_W-1:0] mask_o
);
  import ecc_inj_pkg::*;

  logic [2:0]        mode_q;
  logic [CNT_W-1:0]  rld_q;
  logic [ADDR_W-1:0] cmp_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      rld_q  <= '0;
      cmp_q  <= '0;
      mask_q <= '0;
    end else if (we_i) begin
      unique case (cfg_sel_e'(sel_i))
        SEL_MODE: mode_q <= wdata_i[2:0];
        SEL_RLD:  rld_q  <= wdata_i[CNT_W-1:0];
        SEL_CMP:  cmp_q  <= wdata_i[ADDR_W-1:0];
        SEL_MASK: mask_q <= wdata_i[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  assign mode_o     = mode_q;
  assign rld_o      = rld_q;
  assign cmp_o      = cmp_q;
  assign mask_o     = mask_q;
  // counter takes the new reload value in the same cycle
  assign rld_load_o = we_i && (sel_i == SEL_RLD);
endmodule

// File: rtl/ecc_inj_addr_cmp.sv
module ecc_inj_addr_cmp #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] cmp_i,
  input  logic [ADDR_W-1:0] mask_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] bit_ok;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign bit_ok[i] = ~((addr_i[i] & mask_i[i]) ^ cmp_i[i]);
  end

  assign hit_o = &bit_ok;
endmodule

// File: rtl/ecc_inj_countdown.sv
module ecc_inj_countdown #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             valid_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] rld_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             step;
  logic             last;

  assign step     = run_i && valid_i && !load_i && (rld_i != '0);
  assign last     = (cnt_q <= CNT_W'(1));
  assign expire_o = step && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (step)    cnt_q <= last ? rld_i : cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/ecc_inj_pulse_arm.sv
module ecc_inj_pulse_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pulse_i,
  input  logic valid_i,
  output logic fire_o
);
  logic armed_q;

  assign fire_o = en_i && valid_i && (armed_q || pulse_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (!en_i)   armed_q <= 1'b0;
    else if (fire_o)  armed_q <= 1'b0;
    else if (pulse_i) armed_q <= 1'b1;
  end
endmodule

// File: rtl/ecc_wr_injector.sv
module ecc_wr_injector #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned CHK_W   = 8,
  parameter int unsigned FLIP_LO = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              lat_pulse_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [CHK_W-1:0]  chk_o,
  output logic              inj_o
);
  import ecc_inj_pkg::*;

  // two adjacent flipped bits: always a double error for SECDED
  localparam logic [CHK_W-1:0] FLIP_MASK =
    (CHK_W'(1) << FLIP_LO) | (CHK_W'(1) << (FLIP_LO + 1));

  logic [2:0]        mode_q;
  logic [CNT_W-1:0]  rld;
  logic              rld_load;
  logic [ADDR_W-1:0] cmp, mask;
  logic              addr_hit, cnt_expire, pulse_fire, fire;

  ecc_inj_regs #(.DATA_W(32), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .mode_o(mode_q), .rld_o(rld), .rld_load_o(rld_load),
    .cmp_o(cmp), .mask_o(mask)
  );

  ecc_inj_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .addr_i(wr_addr_i), .cmp_i(cmp), .mask_i(mask), .hit_o(addr_hit)
  );

  ecc_inj_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .run_i(mode_q[2:1] == 2'b11),
    .valid_i(wr_valid_i),
    .load_i(rld_load),
    .load_val_i(cfg_wdata_i[CNT_W-1:0]),
    .rld_i(rld),
    .expire_o(cnt_expire)
  );

  ecc_inj_pulse_arm u_arm (
    .clk_i, .rst_ni,
    .en_i(mode_q == MODE_PULSE),
    .pulse_i(lat_pulse_i),
    .valid_i(wr_valid_i),
    .fire_o(pulse_fire)
  );

  always_comb begin
    unique case (mode_q)
      MODE_PULSE: fire = pulse_fire;
      MODE_ADDR:  fire = wr_valid_i && addr_hit;
      MODE_COUNT: fire = cnt_expire;
      default:    fire = 1'b0;
    endcase
  end

  for (genvar i = 0; i < CHK_W; i++) begin : g_flip
    assign chk_o[i] = chk_i[i] ^ (fire & FLIP_MASK[i]);
  end

  assign inj_o = fire;
endmodule

// File: rtl/ecc_wr_injector_chk.sv
module ecc_wr_injector_chk #(
  parameter int unsigned CHK_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_valid_i,
  input logic [CHK_W-1:0] chk_i,
  input logic [CHK_W-1:0] chk_o,
  input logic             inj_o,
  input logic [2:0]       mode_q
);
  // R10
  inj_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_o |-> wr_valid_i);

  // R3
  double_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_o |-> ($countones(chk_o ^ chk_i) == 2));

  // R3
  clean_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inj_o |-> (chk_o == chk_i));

  // R4
  idle_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q[2] || mode_q == 3'b110) |-> !inj_o);
endmodule

bind ecc_wr_injector ecc_wr_injector_chk #(.CHK_W(CHK_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i),
  .chk_i(chk_i), .chk_o(chk_o), .inj_o(inj_o), .mode_q(mode_q)
);

// File: tb/sim_ecc_wr_injector.sv
`timescale 1ns/1ps
module sim_ecc_wr_injector;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_sel_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        wr_valid_i = 1'b0;
  logic [31:0] wr_addr_i = '0;
  logic        lat_pulse_i = 1'b0;
  logic [7:0]  chk_i = '0;
  logic [7:0]  chk_o;
  logic        inj_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ecc_wr_injector u0 (
    .clk_i(clk), .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_wdata_i,
    .wr_valid_i, .wr_addr_i, .lat_pulse_i, .chk_i, .chk_o, .inj_o
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual inj/chk=%h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    wr_valid_i = 1'b0; lat_pulse_i = 1'b0;
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = val;
    @(posedge clk); #0.5;
    cfg_we_i = 1'b0;
  endtask

  task automatic chunk(input logic v, input logic [31:0] a, input logic p,
                       input logic [7:0] c, input logic exp_inj, input string req);
    logic [7:0] exp_c;
    @(negedge clk);
    wr_valid_i = v; wr_addr_i = a; lat_pulse_i = p; chk_i = c;
    #0.5;
    exp_c = exp_inj ? (c ^ 8'h03) : c;
    check(req, {inj_o, chk_o}, {exp_inj, exp_c});
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    wr_valid_i = 1'b0; lat_pulse_i = 1'b0;
  endtask

  task automatic t_reset();
    chunk(1'b1, 32'h0, 1'b1, 8'h5A, 1'b0, "R1 reset pass-through");
  endtask

  task automatic t_idle_modes();
    // compare=mask=0 matches every address, pulse high each chunk
    chunk(1'b1, 32'hDEAD_BEEF, 1'b1, 8'hFF, 1'b0, "R4 mode 000");
    wr_reg(2'd0, 32'h6);
    chunk(1'b1, 32'h0, 1'b1, 8'h10, 1'b0, "R4 mode 110");
    wr_reg(2'd0, 32'h3);
    chunk(1'b1, 32'h0, 1'b1, 8'h21, 1'b0, "R4 mode 011");
    // pulse outside mode 100 must not arm
    chunk(1'b0, 32'h0, 1'b1, 8'h00, 1'b0, "R5 no arm outside");
    wr_reg(2'd0, 32'h4);
    chunk(1'b1, 32'h0, 1'b0, 8'h33, 1'b0, "R5 no arm outside");
  endtask

  task automatic t_addr();
    wr_reg(2'd3, 32'hFFFF_0000);
    wr_reg(2'd2, 32'h1234_0000);
    wr_reg(2'd0, 32'h5);
    chunk(1'b1, 32'h1234_5678, 1'b0, 8'hA5, 1'b1, "R6 R3 R2 addr hit");
    chunk(1'b1, 32'h1235_0000, 1'b0, 8'hA5, 1'b0, "R6 addr miss");
    chunk(1'b1, 32'h1234_FFFF, 1'b0, 8'h00, 1'b1, "R6 addr hit 2");
    chunk(1'b0, 32'h1234_0000, 1'b0, 8'h77, 1'b0, "R10 invalid no inj");
  endtask

  task automatic t_pulse();
    wr_reg(2'd0, 32'h4);
    chunk(1'b0, 32'h0, 1'b1, 8'h00, 1'b0, "R5 arm, no chunk");
    chunk(1'b0, 32'h0, 1'b0, 8'h00, 1'b0, "R10 armed, invalid");
    chunk(1'b1, 32'h0, 1'b0, 8'hC4, 1'b1, "R5 armed chunk");
    chunk(1'b1, 32'h0, 1'b0, 8'hC4, 1'b0, "R5 one-shot spent");
    chunk(1'b1, 32'h0, 1'b1, 8'h81, 1'b1, "R5 same-cycle pulse");
    chunk(1'b0, 32'h0, 1'b1, 8'h00, 1'b0, "R5 pulse a");
    chunk(1'b0, 32'h0, 1'b1, 8'h00, 1'b0, "R5 pulse b");
    chunk(1'b1, 32'h0, 1'b0, 8'h02, 1'b1, "R5 double pulse first");
    chunk(1'b1, 32'h0, 1'b0, 8'h02, 1'b0, "R5 double pulse no second");
    chunk(1'b0, 32'h0, 1'b1, 8'h00, 1'b0, "R11 arm");
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd0, 32'h4);
    chunk(1'b1, 32'h0, 1'b0, 8'h9C, 1'b0, "R11 arm discarded");
  endtask

  task automatic t_count();
    logic [6:0] pat = 7'b0100100; // bit i = chunk i+1
    wr_reg(2'd1, 32'd3);
    wr_reg(2'd0, 32'h7);
    for (int i = 0; i < 7; i++)
      chunk(1'b1, 32'h0, 1'b0, 8'(i * 17), pat[i], "R7 period 3");
    wr_reg(2'd0, 32'h6);
    chunk(1'b1, 32'h0, 1'b0, 8'h40, 1'b0, "R9 counts in 110");
    chunk(1'b1, 32'h0, 1'b0, 8'h41, 1'b0, "R9 expiry silent in 110");
    wr_reg(2'd0, 32'h7);
    chunk(1'b1, 32'h0, 1'b0, 8'h50, 1'b0, "R9 after 110");
    chunk(1'b1, 32'h0, 1'b0, 8'h51, 1'b0, "R9 after 110");
    chunk(1'b1, 32'h0, 1'b0, 8'h52, 1'b1, "R9 reloaded in 110");
    wr_reg(2'd0, 32'h0);
    chunk(1'b1, 32'h0, 1'b0, 8'h60, 1'b0, "R9 held in 000");
    chunk(1'b1, 32'h0, 1'b0, 8'h61, 1'b0, "R9 held in 000");
    wr_reg(2'd0, 32'h7);
    chunk(1'b1, 32'h0, 1'b0, 8'h62, 1'b0, "R9 resume");
    chunk(1'b0, 32'h0, 1'b0, 8'h00, 1'b0, "R10 no advance");
    chunk(1'b1, 32'h0, 1'b0, 8'h63, 1'b0, "R9 resume");
    chunk(1'b1, 32'h0, 1'b0, 8'h64, 1'b1, "R9 held value 3");
    wr_reg(2'd1, 32'd0);
    for (int i = 0; i < 4; i++)
      chunk(1'b1, 32'h0, 1'b0, 8'hE0, 1'b0, "R8 zero disables");
    wr_reg(2'd1, 32'd1);
    for (int i = 0; i < 3; i++)
      chunk(1'b1, 32'h0, 1'b0, 8'hF0, 1'b1, "R8 immediate load 1");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    t_reset();
    t_idle_modes();
    t_addr();
    t_pulse();
    t_count();
    idle();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule